// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor that keeps one 16-bit accumulator and talks to a synchronous, byte-addressed memory of 16 KB. Every memory access goes through two holding registers: an address register that drives the address bus and a buffer register that captures read data or holds write data. A sequencer steps through one register transfer per clock. It fetches the instruction word into the instruction register and decodes it. It then moves the operand address into the address register, reads or writes the operand, updates the accumulator, and advances the program counter by one 16-bit word (two bytes).

The core runs five data instructions: load, store, add, subtract and multiply (low half of the product). It also has a stop instruction, which freezes the sequencer and raises a status output. This lets a test environment let a program run to completion and then inspect memory. Opcodes that are not assigned are skipped and have no effect. The memory answers a read one cycle after the request. A write takes effect in the cycle the request is presented.

Top module: `acc_core`

## Requirements
- R1: While reset is high, the registers are cleared, so mem_en, mem_addr, mem_wdata and halted are all zero. The program counter is loaded with START_ADDR, and the first memory access after reset is a read of byte address START_ADDR.
- R2: Instruction fetches read consecutive 16-bit words, at START_ADDR, START_ADDR+2, START_ADDR+4 and so on. There are no branches.
- R3: The instruction word holds the opcode in bits 15:13 and a 13-bit word address in bits 12:0. The operand byte address is that field shifted left by one, so every access has address bit 0 equal to 0. The opcodes are: load 000 (accumulator takes M[X]), store 001, add 010, subtract 011, multiply 100, stop 111. Codes 101 and 110 are unassigned.
- R4: Store places the accumulator value on mem_wdata at the operand address, with mem_en and mem_rw both high for exactly one cycle per store. mem_rw high means write.
- R5: Add sets the accumulator to (accumulator + M[X]) modulo 2^16.
- R6: Subtract sets the accumulator to (accumulator - M[X]) modulo 2^16.
- R7: Multiply sets the accumulator to the low 16 bits of accumulator times M[X]. The program (x+y)*(x-y) stores the correct low 16 bits.
- R8: An unassigned opcode changes neither the accumulator nor memory, and execution continues at the next word.
- R9: After the stop opcode is decoded, halted stays high and no further memory access is made until reset.
- R10: Load, add, subtract and multiply each take 9 cycles, store takes 8, and an unassigned opcode takes 6. Halted rises 5 cycles after the stop instruction's fetch begins. A read request is never followed by another access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory access request for this cycle |
| mem_rw | output | 1 | 1 = write, 0 = read; valid when mem_en is high |
| mem_addr | output | 14 | Byte address, driven by the address register |
| mem_wdata | output | 16 | Write data, driven by the buffer register |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| halted | output | 1 | High once the stop opcode has been decoded |

## Verification
Internal state leaves this core only through memory traffic. A wrong program counter therefore shows up at the next fetch, about five cycles later, as an out-of-sequence fetch address. A wrong accumulator or a wrong ALU operation shows up only when a later store writes a bad word. That may be many instructions later, so each program's data region is compared word for word against a reference interpreter once the core stops. A wrong sequencer transition shows up at once as a misplaced access, and over the whole program as a total cycle count that differs from the per-opcode cycle budget.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    parameter int DATA_W     = 16;
    parameter int ADDR_W     = 14;
    parameter int OPC_W      = 3;
    parameter int WADDR_W    = DATA_W - OPC_W;
    parameter int WORD_BYTES = DATA_W / 8;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 3'd0,
        OPC_STORE = 3'd1,
        OPC_ADD   = 3'd2,
        OPC_SUB   = 3'd3,
        OPC_MUL   = 3'd4,
        OPC_STOP  = 3'd7
    } opcode_e;

    typedef enum logic [3:0] {
        SQ_FETCH_ADDR,
        SQ_FETCH_REQ,
        SQ_FETCH_CAP,
        SQ_FETCH_IR,
        SQ_DECODE,
        SQ_OPND_REQ,
        SQ_OPND_CAP,
        SQ_EXEC,
        SQ_STORE_LOAD,
        SQ_STORE_WR,
        SQ_PC_STEP,
        SQ_STOPPED
    } seq_state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_MUL
    } alu_fn_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [WADDR_W-1:0] waddr;
    } instr_t;

    typedef struct packed {
        logic    mar_from_pc;
        logic    mar_from_ir;
        logic    mbr_from_mem;
        logic    mbr_from_acc;
        logic    ir_load;
        logic    acc_load;
        logic    pc_step;
        alu_fn_e alu_fn;
    } dp_ctrl_t;

    function automatic alu_fn_e alu_fn_for(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_ADD: return ALU_ADD;
            OPC_SUB: return ALU_SUB;
            OPC_MUL: return ALU_MUL;
            default: return ALU_PASS;
        endcase
    endfunction

    function automatic logic needs_read(input logic [OPC_W-1:0] opc);
        return (opc == OPC_LOAD) || (opc == OPC_ADD) ||
               (opc == OPC_SUB)  || (opc == OPC_MUL);
    endfunction

    function automatic logic [ADDR_W-1:0] word_to_byte(input logic [WADDR_W-1:0] w);
        return {w, 1'b0};
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
(
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_incr.sv
module acc_incr #(
    parameter int W    = 14,
    parameter int STEP = 2
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] STEP_V = W'(STEP);

    assign y = a + STEP_V;

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_core_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  dp_ctrl_t          ctrl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mbr_q,
    output instr_t            ir_q
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_inc;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] alu_y;

    acc_incr #(.W(ADDR_W), .STEP(WORD_BYTES)) u_inc (
        .a (pc_q),
        .y (pc_inc)
    );

    acc_alu u_alu (
        .fn (ctrl.alu_fn),
        .a  (acc_q),
        .b  (mbr_q),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= START_ADDR;
            mar_q <= '0;
            mbr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            if (ctrl.pc_step)
                pc_q <= pc_inc;
            if (ctrl.mar_from_pc)
                mar_q <= pc_q;
            else if (ctrl.mar_from_ir)
                mar_q <= word_to_byte(ir_q.waddr);
            if (ctrl.mbr_from_mem)
                mbr_q <= mem_rdata;
            else if (ctrl.mbr_from_acc)
                mbr_q <= acc_q;
            if (ctrl.ir_load)
                ir_q <= instr_t'(mbr_q);
            if (ctrl.acc_load)
                acc_q <= alu_y;
        end
    end

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] ir_opc,
    output dp_ctrl_t         ctrl,
    output logic             mem_en,
    output logic             mem_rw,
    output logic             stopped
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SQ_FETCH_ADDR;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ctrl    = '0;
        mem_en  = 1'b0;
        mem_rw  = 1'b0;
        case (state_q)
            SQ_FETCH_ADDR: begin
                ctrl.mar_from_pc = 1'b1;
                state_d = SQ_FETCH_REQ;
            end
            SQ_FETCH_REQ: begin
                mem_en  = 1'b1;
                state_d = SQ_FETCH_CAP;
            end
            SQ_FETCH_CAP: begin
                ctrl.mbr_from_mem = 1'b1;
                state_d = SQ_FETCH_IR;
            end
            SQ_FETCH_IR: begin
                ctrl.ir_load = 1'b1;
                state_d = SQ_DECODE;
            end
            SQ_DECODE: begin
                if (ir_opc == OPC_STOP) begin
                    state_d = SQ_STOPPED;
                end else if (ir_opc == OPC_STORE) begin
                    ctrl.mar_from_ir = 1'b1;
                    state_d = SQ_STORE_LOAD;
                end else if (needs_read(ir_opc)) begin
                    ctrl.mar_from_ir = 1'b1;
                    state_d = SQ_OPND_REQ;
                end else begin
                    state_d = SQ_PC_STEP;
                end
            end
            SQ_OPND_REQ: begin
                mem_en  = 1'b1;
                state_d = SQ_OPND_CAP;
            end
            SQ_OPND_CAP: begin
                ctrl.mbr_from_mem = 1'b1;
                state_d = SQ_EXEC;
            end
            SQ_EXEC: begin
                ctrl.acc_load = 1'b1;
                ctrl.alu_fn   = alu_fn_for(ir_opc);
                state_d = SQ_PC_STEP;
            end
            SQ_STORE_LOAD: begin
                ctrl.mbr_from_acc = 1'b1;
                state_d = SQ_STORE_WR;
            end
            SQ_STORE_WR: begin
                mem_en  = 1'b1;
                mem_rw  = 1'b1;
                state_d = SQ_PC_STEP;
            end
            SQ_PC_STEP: begin
                ctrl.pc_step = 1'b1;
                state_d = SQ_FETCH_ADDR;
            end
            SQ_STOPPED: begin
                state_d = SQ_STOPPED;
            end
            default: begin
                state_d = SQ_FETCH_ADDR;
            end
        endcase
    end

    assign stopped = (state_q == SQ_STOPPED);

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_ADDR = 14'h0100
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_en,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);

    dp_ctrl_t          dp_ctrl;
    instr_t            ir_w;
    logic [ADDR_W-1:0] mar_w;
    logic [DATA_W-1:0] mbr_w;

    acc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ir_opc  (ir_w.opc),
        .ctrl    (dp_ctrl),
        .mem_en  (mem_en),
        .mem_rw  (mem_rw),
        .stopped (halted)
    );

    acc_datapath #(.START_ADDR(START_ADDR)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (dp_ctrl),
        .mem_rdata (mem_rdata),
        .mar_q     (mar_w),
        .mbr_q     (mbr_w),
        .ir_q      (ir_w)
    );

    assign mem_addr  = mar_w;
    assign mem_wdata = mbr_w;

endmodule

// File: rtl/acc_core_checker.sv
module acc_core_checker (
    input logic clk,
    input logic rst,
    input logic mem_en,
    input logic mem_rw,
    input logic addr_lsb,
    input logic halted
);

    // R4: a write request lasts a single cycle
    assert_write_single_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_rw) |=> !(mem_en && mem_rw));

    // R4: write strobe only accompanies an enabled access
    assert_rw_with_en_R4: assert property (@(posedge clk) disable iff (rst)
        mem_rw |-> mem_en);

    // R3: all accesses are word aligned
    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> !addr_lsb);

    // R9: once stopped, stays stopped
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R9: no memory traffic while stopped
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_en);

    // R10: a read request is followed by an idle bus cycle
    assert_read_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_rw) |=> !mem_en);

endmodule

bind acc_core acc_core_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_en   (mem_en),
    .mem_rw   (mem_rw),
    .addr_lsb (mem_addr[0]),
    .halted   (halted)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [13:0] START      = 14'h0100;
    localparam int          MEM_WORDS  = 1024;
    localparam int          DATA_BASE  = 'h200;
    localparam int          DATA_LEN   = 64;
    localparam int          PROG_LIMIT = 'h400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_en;
    logic        mem_rw;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        halted;

    logic [15:0] mem     [0:MEM_WORDS-1];
    logic [15:0] ref_mem [0:MEM_WORDS-1];

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int cyc = 0;
    int halt_cyc = -1;
    int wr_cnt = 0;
    int quiet_viol = 0;
    int fetch_err = 0;
    int fetch_idx = 0;
    bit first_seen = 0;
    logic [13:0] first_addr = '0;
    logic        first_rw = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core #(.START_ADDR(START)) u_acc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_en    (mem_en),
        .mem_rw    (mem_rw),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // synchronous memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_rw)
                mem[mem_addr[10:1]] <= mem_wdata;
            else
                mem_rdata <= mem[mem_addr[10:1]];
        end
    end

    always @(posedge clk) begin
        if (!rst) cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_en && mem_rw) wr_cnt++;
            if (mem_en && halted) quiet_viol++;
            if (mem_en && !first_seen) begin
                first_seen = 1;
                first_addr = mem_addr;
                first_rw   = mem_rw;
            end
            if (mem_en && !mem_rw && (mem_addr < 14'(PROG_LIMIT))) begin
                if (mem_addr != START + 14'(2 * fetch_idx)) fetch_err++;
                fetch_idx++;
            end
            if (halted && halt_cyc < 0) halt_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input logic [2:0] op, input int widx);
        return {op, 13'(widx)};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    endtask

    // reference interpreter: returns expected cycles to halt and store count
    task automatic run_ref(output int cycles, output int writes);
        logic [15:0] acc = '0;
        logic [13:0] pc = START;
        bit stop = 0;
        cycles = 0;
        writes = 0;
        for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = mem[i];
        for (int step = 0; step < 200 && !stop; step++) begin
            logic [15:0] w;
            int idx;
            w = ref_mem[pc[10:1]];
            idx = int'(w[9:0]);
            case (w[15:13])
                3'd0: begin acc = ref_mem[idx];       cycles += 9; end
                3'd1: begin ref_mem[idx] = acc;       cycles += 8; writes++; end
                3'd2: begin acc = acc + ref_mem[idx]; cycles += 9; end
                3'd3: begin acc = acc - ref_mem[idx]; cycles += 9; end
                3'd4: begin acc = acc * ref_mem[idx]; cycles += 9; end
                3'd7: begin cycles += 5; stop = 1; end
                default: cycles += 6;
            endcase
            pc = pc + 14'd2;
        end
    endtask

    task automatic run_prog(input string tag);
        int exp_cyc;
        int exp_wr;
        int guard;
        rst = 1'b1;
        run_ref(exp_cyc, exp_wr);
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(mem_en == 1'b0 && halted == 1'b0, "R1 reset strobes", {mem_en, halted}, 0);
        chk(mem_addr == '0 && mem_wdata == '0, "R1 reset address/data", {mem_addr, mem_wdata}, 0);
        cyc = 0; halt_cyc = -1; wr_cnt = 0; quiet_viol = 0;
        fetch_err = 0; fetch_idx = 0; first_seen = 0;
        @(posedge clk);
        #1 rst = 1'b0;
        guard = 0;
        while (!halted && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
        chk(first_seen && first_addr == START && first_rw == 1'b0, "R1 first fetch", {first_rw, first_addr}, START);
        chk(halted == 1'b1, "R9 halted", halted, 1);
        chk(quiet_viol == 0, "R9 quiet after stop", quiet_viol, 0);
        chk(halt_cyc == exp_cyc, "R10 cycles to stop", halt_cyc, exp_cyc);
        chk(wr_cnt == exp_wr, "R4 write strobes", wr_cnt, exp_wr);
        chk(fetch_err == 0, "R2 fetch sequence", fetch_err, 0);
        for (int i = DATA_BASE; i < DATA_BASE + DATA_LEN; i++)
            chk(mem[i] === ref_mem[i], tag, mem[i], ref_mem[i]);
    endtask

    // (x+y)*(x-y) program: X, Y, T, A at DATA_BASE+0..3
    task automatic load_poly(input logic [15:0] x, input logic [15:0] y);
        int p;
        clear_mem();
        mem[DATA_BASE]     = x;
        mem[DATA_BASE + 1] = y;
        p = int'(START) / 2;
        mem[p++] = ins(3'd0, DATA_BASE);
        mem[p++] = ins(3'd2, DATA_BASE + 1);
        mem[p++] = ins(3'd1, DATA_BASE + 2);
        mem[p++] = ins(3'd0, DATA_BASE);
        mem[p++] = ins(3'd3, DATA_BASE + 1);
        mem[p++] = ins(3'd4, DATA_BASE + 2);
        mem[p++] = ins(3'd1, DATA_BASE + 3);
        mem[p++] = ins(3'd7, 0);
    endtask

    initial begin
        int p;
        int unsigned seed;
        logic [15:0] expv;
        seed = $urandom(32'd20240611);

        // R7: directed (x+y)*(x-y), checked against closed form as well
        load_poly(16'd7, 16'd3);
        run_prog("R7 poly");
        chk(mem[DATA_BASE + 3] == 16'd40, "R7 poly result", mem[DATA_BASE + 3], 40);

        // R5/R6/R7: wrap-around values
        load_poly(16'hFFFF, 16'h0002);
        run_prog("R5 wrap");
        expv = (16'hFFFF + 16'h0002) * (16'hFFFF - 16'h0002);
        chk(mem[DATA_BASE + 3] == expv, "R7 wrapped product", mem[DATA_BASE + 3], expv);

        load_poly(16'd3, 16'd5);
        run_prog("R6 negative diff");
        chk(mem[DATA_BASE + 2] == 16'd8, "R5 sum stored", mem[DATA_BASE + 2], 8);
        chk(mem[DATA_BASE + 3] == 16'hFFF0, "R6 negative product", mem[DATA_BASE + 3], 16'hFFF0);

        // R8: unassigned opcodes between load and store
        clear_mem();
        mem[DATA_BASE] = 16'hBEEF;
        mem[DATA_BASE + 1] = 16'h1234;
        p = int'(START) / 2;
        mem[p++] = ins(3'd0, DATA_BASE);
        mem[p++] = ins(3'd5, DATA_BASE + 1);
        mem[p++] = ins(3'd6, DATA_BASE + 1);
        mem[p++] = ins(3'd1, DATA_BASE + 2);
        mem[p++] = ins(3'd7, 0);
        run_prog("R8 skip");
        chk(mem[DATA_BASE + 1] == 16'h1234, "R8 memory untouched", mem[DATA_BASE + 1], 16'h1234);
        chk(mem[DATA_BASE + 2] == 16'hBEEF, "R8 acc untouched", mem[DATA_BASE + 2], 16'hBEEF);

        // R3: random programs mixing all opcodes
        for (int r = 0; r < 6; r++) begin
            clear_mem();
            for (int i = 0; i < DATA_LEN; i++) mem[DATA_BASE + i] = 16'($urandom);
            p = int'(START) / 2;
            for (int k = 0; k < 30; k++) begin
                logic [2:0] op;
                op = 3'($urandom_range(0, 6));
                if (op == 3'd5 && $urandom_range(0, 1) == 1) op = 3'd6;
                mem[p++] = ins(op, DATA_BASE + int'($urandom_range(0, DATA_LEN - 1)));
            end
            mem[p++] = ins(3'd7, 0);
            run_prog("R3 random program");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule